// File: doc/BRIEF.md
# Streaming Support Disparity Filter

This block cleans the sparse stream of candidate support disparities produced by a stereo matcher before the candidates are used to build a coarse scene mesh. Candidates arrive in raster order, one per clock, each marked usable or not and carrying a disparity. The block applies two tests. The first is a plausibility test: a usable candidate survives only if enough usable neighbours inside a rectangular window around it hold a disparity close to its own. The second is a redundancy test: a surviving candidate is dropped if a candidate already passed on to the output, a few positions to its left in the same row or a few rows above it in the same column, holds exactly the same disparity.

The redundancy test looks only backwards and compares only against candidates that were actually kept. A long run of equal values is therefore thinned to a regular spacing and does not vanish. The stream is never stored in external memory, and the block accepts and emits one sample on every clock. The image size, window half-sizes, disparity tolerance, minimum support count and redundancy look-back distance are parameters.

Top module: `sp_stream_filter`

## Requirements
- R1: While `rst_n` is low, `out_ok` and `out_sof` are 0.
- R2: The result for the sample taken on clock edge k appears on the outputs just after edge k+LAT, where LAT = HALF_R*IMG_W + HALF_C + 1. `out_sof` is `in_sof` delayed by exactly LAT cycles.
- R3: A sample with `in_ok`=0 never leaves with `out_ok`=1. Every output with `out_ok`=0 carries `out_disp`=0.
- R4: A neighbour supports a candidate when it lies in the (2*HALF_R+1) x (2*HALF_C+1) window centred on the candidate, is not the candidate itself, has `in_ok`=1, and its disparity differs from the candidate's by at most TOL. A usable candidate with fewer than MIN_SUP supporters is suppressed.
- R5: Window positions outside the frame never support a candidate. This covers positions left or right of the row, rows above the first, rows below the last, and samples of neighbouring frames or idle gaps.
- R6: A candidate that passes R4 is suppressed when, for some k in 1..LOOK with column-k >= 0, the output at column-k of the same row was kept with the same disparity.
- R7: A candidate that passes R4 is suppressed when, for some k in 1..LOOK with row-k >= 0, the output at row-k of the same column was kept with the same disparity.
- R8: A candidate that is usable, supported and not redundant is emitted with `out_ok`=1 and its own disparity. Because R6 and R7 compare only with kept outputs, a run of equal values keeps every (LOOK+1)-th entry.
- R9: `in_sof` marks row 0, column 0 of a frame. It restarts the position count, so frames may follow back to back or be separated by idle samples, which must have `in_ok`=0. Successive `in_sof` pulses are at least IMG_W*IMG_H cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_sof | input | 1 | First sample of a frame |
| in_ok | input | 1 | Candidate is usable |
| in_disp | input | DISP_W | Candidate disparity |
| out_sof | output | 1 | First sample of a filtered frame |
| out_ok | output | 1 | Candidate kept |
| out_disp | output | DISP_W | Kept disparity, 0 when not kept |

## Verification
The assertions rely on the input contract. Frame starts must be spaced by at least one full frame, and every sample outside a frame must be marked unusable. Only under that contract do the start-of-frame latency check and the output column count used by the same-row redundancy check remain meaningful. The bench places frames on a single continuous timeline, with idle gaps of zero or more samples between them. Gap samples are always driven unusable and frame starts are never closer than one frame.

// File: rtl/sspf_pkg.sv
`timescale 1ns/1ps
package sspf_pkg;

  // absolute difference within a tolerance
  function automatic logic near(input int a, input int b, input int tol);
    int d;
    d = a - b;
    if (d < 0) d = -d;
    return (d <= tol);
  endfunction

  // coordinate lies on the frame
  function automatic logic on_frame(input int pos, input int lim);
    return (pos >= 0) && (pos < lim);
  endfunction

endpackage

// File: rtl/sspf_rst_sync.sv
`timescale 1ns/1ps
module sspf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end
endmodule

// File: rtl/sspf_window.sv
`timescale 1ns/1ps
module sspf_window #(
  parameter int IMG_W  = 64,
  parameter int IMG_H  = 48,
  parameter int DISP_W = 8,
  parameter int HALF_R = 2,
  parameter int HALF_C = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_sof,
  input  logic                            in_ok,
  input  logic [DISP_W-1:0]               in_disp,
  output logic [(2*HALF_R+1)*(2*HALF_C+1)-1:0]        tap_ok,
  output logic [(2*HALF_R+1)*(2*HALF_C+1)*DISP_W-1:0] tap_disp,
  output logic                            ctr_sof,
  output logic [$clog2(IMG_W)-1:0]        ctr_col,
  output logic [$clog2(IMG_H)-1:0]        ctr_row
);
  localparam int WC   = 2*HALF_C + 1;
  localparam int WR   = 2*HALF_R + 1;
  localparam int LEN  = 2*HALF_R*IMG_W + 2*HALF_C + 1;
  localparam int CIDX = HALF_R*IMG_W + HALF_C;
  localparam int XW   = $clog2(IMG_W);
  localparam int YW   = $clog2(IMG_H);

  logic [LEN-1:0]    ok_q, ok_d, sof_q, sof_d;
  logic [DISP_W-1:0] disp_q [LEN];
  logic [DISP_W-1:0] disp_d [LEN];
  logic [XW-1:0]     col_cur, col_nx_q, col_nx_d;
  logic [YW-1:0]     row_cur, row_nx_q, row_nx_d;

  // delay line spanning the whole window, newest sample at index 0
  always_comb begin
    ok_d  = {ok_q[LEN-2:0], in_ok};
    sof_d = {sof_q[LEN-2:0], in_sof};
    disp_d[0] = in_disp;
    for (int j = 1; j < LEN; j++) disp_d[j] = disp_q[j-1];
  end

  // position of the sample sitting at the window centre
  always_comb begin
    col_cur = ctr_sof ? '0 : col_nx_q;
    row_cur = ctr_sof ? '0 : row_nx_q;
    if (col_cur == XW'(IMG_W-1)) begin
      col_nx_d = '0;
      row_nx_d = (row_cur == YW'(IMG_H-1)) ? '0 : row_cur + 1'b1;
    end else begin
      col_nx_d = col_cur + 1'b1;
      row_nx_d = row_cur;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q     <= '0;
      sof_q    <= '0;
      col_nx_q <= '0;
      row_nx_q <= '0;
      for (int j = 0; j < LEN; j++) disp_q[j] <= '0;
    end else begin
      ok_q     <= ok_d;
      sof_q    <= sof_d;
      col_nx_q <= col_nx_d;
      row_nx_q <= row_nx_d;
      for (int j = 0; j < LEN; j++) disp_q[j] <= disp_d[j];
    end
  end

  assign ctr_sof = sof_q[CIDX];
  assign ctr_col = col_cur;
  assign ctr_row = row_cur;

  // window taps: row offset gr-HALF_R, column offset gc-HALF_C
  for (genvar gr = 0; gr < WR; gr++) begin : g_row
    for (genvar gc = 0; gc < WC; gc++) begin : g_col
      localparam int DIDX = CIDX - (gr-HALF_R)*IMG_W - (gc-HALF_C);
      assign tap_ok[gr*WC+gc]                   = ok_q[DIDX];
      assign tap_disp[(gr*WC+gc)*DISP_W +: DISP_W] = disp_q[DIDX];
    end
  end
endmodule

// File: rtl/sspf_support.sv
`timescale 1ns/1ps
module sspf_support
  import sspf_pkg::*;
#(
  parameter int IMG_W   = 64,
  parameter int IMG_H   = 48,
  parameter int DISP_W  = 8,
  parameter int HALF_R  = 2,
  parameter int HALF_C  = 2,
  parameter int TOL     = 5,
  parameter int MIN_SUP = 10
) (
  input  logic [(2*HALF_R+1)*(2*HALF_C+1)-1:0]        tap_ok,
  input  logic [(2*HALF_R+1)*(2*HALF_C+1)*DISP_W-1:0] tap_disp,
  input  logic [$clog2(IMG_W)-1:0]        ctr_col,
  input  logic [$clog2(IMG_H)-1:0]        ctr_row,
  output logic                            pass,
  output logic [DISP_W-1:0]               ctr_disp
);
  localparam int WC = 2*HALF_C + 1;
  localparam int WR = 2*HALF_R + 1;
  localparam int CT = HALF_R*WC + HALF_C;

  int votes;
  int nr, nc, ti;

  assign ctr_disp = tap_disp[CT*DISP_W +: DISP_W];

  always_comb begin
    votes = 0;
    nr = 0;
    nc = 0;
    ti = 0;
    for (int gr = 0; gr < WR; gr++) begin
      for (int gc = 0; gc < WC; gc++) begin
        ti = gr*WC + gc;
        nr = int'(ctr_row) + gr - HALF_R;
        nc = int'(ctr_col) + gc - HALF_C;
        if (ti != CT && tap_ok[ti] && on_frame(nr, IMG_H) && on_frame(nc, IMG_W)
            && near(int'(tap_disp[ti*DISP_W +: DISP_W]), int'(ctr_disp), TOL))
          votes = votes + 1;
      end
    end
    pass = tap_ok[CT] && (votes >= MIN_SUP);
  end
endmodule

// File: rtl/sspf_redund.sv
`timescale 1ns/1ps
module sspf_redund #(
  parameter int IMG_W  = 64,
  parameter int IMG_H  = 48,
  parameter int DISP_W = 8,
  parameter int LOOK   = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pass,
  input  logic [DISP_W-1:0]        ctr_disp,
  input  logic                     ctr_sof,
  input  logic [$clog2(IMG_W)-1:0] ctr_col,
  input  logic [$clog2(IMG_H)-1:0] ctr_row,
  output logic                     out_sof,
  output logic                     out_ok,
  output logic [DISP_W-1:0]        out_disp
);
  // history of kept decisions; index j is j+1 samples behind the centre
  localparam int HL = LOOK*IMG_W;

  logic [HL-1:0]     hok_q, hok_d;
  logic [DISP_W-1:0] hdisp_q [HL];
  logic [DISP_W-1:0] hdisp_d [HL];
  logic              dup, keep, sof_q;

  always_comb begin
    dup = 1'b0;
    for (int k = 1; k <= LOOK; k++) begin
      if (int'(ctr_col) >= k && hok_q[k-1] && hdisp_q[k-1] == ctr_disp)
        dup = 1'b1;
      if (int'(ctr_row) >= k && hok_q[k*IMG_W-1] && hdisp_q[k*IMG_W-1] == ctr_disp)
        dup = 1'b1;
    end
    keep  = pass && !dup;
    hok_d = {hok_q[HL-2:0], keep};
    hdisp_d[0] = keep ? ctr_disp : '0;
    for (int j = 1; j < HL; j++) hdisp_d[j] = hdisp_q[j-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hok_q <= '0;
      sof_q <= 1'b0;
      for (int j = 0; j < HL; j++) hdisp_q[j] <= '0;
    end else begin
      hok_q <= hok_d;
      sof_q <= ctr_sof;
      for (int j = 0; j < HL; j++) hdisp_q[j] <= hdisp_d[j];
    end
  end

  assign out_ok   = hok_q[0];
  assign out_disp = hdisp_q[0];
  assign out_sof  = sof_q;
endmodule

// File: rtl/sp_stream_filter.sv
`timescale 1ns/1ps
module sp_stream_filter #(
  parameter int IMG_W   = 64,
  parameter int IMG_H   = 48,
  parameter int DISP_W  = 8,
  parameter int HALF_R  = 2,
  parameter int HALF_C  = 2,
  parameter int TOL     = 5,
  parameter int MIN_SUP = 10,
  parameter int LOOK    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_sof,
  input  logic              in_ok,
  input  logic [DISP_W-1:0] in_disp,
  output logic              out_sof,
  output logic              out_ok,
  output logic [DISP_W-1:0] out_disp
);
  localparam int NWIN = (2*HALF_R+1)*(2*HALF_C+1);
  localparam int XW   = $clog2(IMG_W);
  localparam int YW   = $clog2(IMG_H);

  logic                   srst_n;
  logic [NWIN-1:0]        tap_ok;
  logic [NWIN*DISP_W-1:0] tap_disp;
  logic                   ctr_sof, pass;
  logic [XW-1:0]          ctr_col;
  logic [YW-1:0]          ctr_row;
  logic [DISP_W-1:0]      ctr_disp;

  sspf_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  sspf_window #(.IMG_W(IMG_W), .IMG_H(IMG_H), .DISP_W(DISP_W),
                .HALF_R(HALF_R), .HALF_C(HALF_C)) u_win (
    .clk(clk), .rst_n(srst_n), .in_sof(in_sof), .in_ok(in_ok), .in_disp(in_disp),
    .tap_ok(tap_ok), .tap_disp(tap_disp), .ctr_sof(ctr_sof),
    .ctr_col(ctr_col), .ctr_row(ctr_row));

  sspf_support #(.IMG_W(IMG_W), .IMG_H(IMG_H), .DISP_W(DISP_W), .HALF_R(HALF_R),
                 .HALF_C(HALF_C), .TOL(TOL), .MIN_SUP(MIN_SUP)) u_sup (
    .tap_ok(tap_ok), .tap_disp(tap_disp), .ctr_col(ctr_col), .ctr_row(ctr_row),
    .pass(pass), .ctr_disp(ctr_disp));

  sspf_redund #(.IMG_W(IMG_W), .IMG_H(IMG_H), .DISP_W(DISP_W), .LOOK(LOOK)) u_red (
    .clk(clk), .rst_n(srst_n), .pass(pass), .ctr_disp(ctr_disp), .ctr_sof(ctr_sof),
    .ctr_col(ctr_col), .ctr_row(ctr_row),
    .out_sof(out_sof), .out_ok(out_ok), .out_disp(out_disp));
endmodule

// File: rtl/sspf_checks.sv
`timescale 1ns/1ps
module sspf_checks #(
  parameter int IMG_W  = 64,
  parameter int IMG_H  = 48,
  parameter int DISP_W = 8,
  parameter int HALF_R = 2,
  parameter int HALF_C = 2,
  parameter int LOOK   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_sof,
  input logic              out_sof,
  input logic              out_ok,
  input logic [DISP_W-1:0] out_disp
);
  localparam int LAT   = HALF_R*IMG_W + HALF_C + 1;
  localparam int FRAME = IMG_W*IMG_H;
  localparam int CMAX  = FRAME + LAT + 2;

  int   since_q;
  logic seen_q;
  int   ocol_q;
  logic oseen_q;
  int   col_now;

  always_comb col_now = out_sof ? 0 : ((ocol_q == IMG_W-1) ? 0 : ocol_q + 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= 0;
      seen_q  <= 1'b0;
      ocol_q  <= 0;
      oseen_q <= 1'b0;
    end else begin
      if (in_sof) begin
        since_q <= 1;
        seen_q  <= 1'b1;
      end else if (since_q < CMAX) begin
        since_q <= since_q + 1;
      end
      ocol_q <= col_now;
      if (out_sof) oseen_q <= 1'b1;
    end
  end

  // R1
  always @(posedge clk) begin
    if (!rst_n) a_r1_reset_quiet: assert (!out_ok && !out_sof);
  end

  // R2
  a_r2_sof_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof == (seen_q && since_q == LAT + 1));

  // R9 (input contract)
  a_r9_sof_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sof && seen_q) |-> (since_q >= FRAME));

  // R6, nearest left neighbour
  a_r6_row_step1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ok && (oseen_q || out_sof) && col_now >= 1 && $past(out_ok))
      |-> (out_disp != $past(out_disp)));

  if (LOOK >= 2) begin : g_k2
    // R6, two to the left
    a_r6_row_step2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_ok && (oseen_q || out_sof) && col_now >= 2 && $past(out_ok, 2))
        |-> (out_disp != $past(out_disp, 2)));
  end
endmodule

bind sp_stream_filter sspf_checks #(
  .IMG_W(IMG_W), .IMG_H(IMG_H), .DISP_W(DISP_W),
  .HALF_R(HALF_R), .HALF_C(HALF_C), .LOOK(LOOK)
) u_checks (
  .clk(clk), .rst_n(rst_n), .in_sof(in_sof),
  .out_sof(out_sof), .out_ok(out_ok), .out_disp(out_disp)
);

// File: tb/sp_stream_filter_bench.sv
`timescale 1ns/1ps
module sp_stream_filter_bench;
  localparam int W = 12, H = 8, DW = 4, HR = 1, HC = 1, TOL = 1, MINS = 3, LOOK = 2;
  localparam int LAT = HR*W + HC + 1;
  localparam int N = 600;

  logic clk = 1'b0;
  logic rst_n, in_sof, in_ok, out_sof, out_ok;
  logic [DW-1:0] in_disp, out_disp;

  always #2 clk = ~clk;

  sp_stream_filter #(.IMG_W(W), .IMG_H(H), .DISP_W(DW), .HALF_R(HR), .HALF_C(HC),
                     .TOL(TOL), .MIN_SUP(MINS), .LOOK(LOOK)) u_sp_stream_filter (
    .clk(clk), .rst_n(rst_n), .in_sof(in_sof), .in_ok(in_ok), .in_disp(in_disp),
    .out_sof(out_sof), .out_ok(out_ok), .out_disp(out_disp));

  int vectors = 0, errors = 0;
  bit done = 0;
  bit st_sof [N]; bit st_ok [N]; int st_d [N];
  bit ex_ok [N]; int ex_d [N]; int ex_why [N];
  int fo [H][W]; int fd [H][W]; int kept [H][W];
  logic [31:0] seed = 32'h1234_5678;
  int ns;

  function automatic int rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed[23:16]);
  endfunction

  function automatic string tag(int why, bit sof);
    if (sof) return "R2 R9";
    case (why)
      1: return "R3";
      2: return "R4";
      6: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      default: return "R2";
    endcase
  endfunction

  // build frame pattern f, compute expected results, place at stream position p
  task automatic place(input int f, input int p);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        case (f)
          0: begin fo[r][c] = 1; fd[r][c] = 7; end
          1: begin fo[r][c] = ((r + c) % 3 != 0); fd[r][c] = (c/2 + r/3) % 16; end
          2: begin fo[r][c] = (rnd() % 4 != 0); fd[r][c] = 3 + rnd() % 4; end
          3: begin fo[r][c] = 1; fd[r][c] = c % 16; end
          default: begin
            fo[r][c] = 1; fd[r][c] = 4 + r % 2;
            if ((r == 0 && c == 0) || (r == 3 && c == 5) || (r == H-1 && c == W-1))
              fd[r][c] = 12;
          end
        endcase
      end
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        int sup, why, i;
        bit edge_near;
        sup = 0;
        edge_near = (r < HR) || (r >= H-HR) || (c < HC) || (c >= W-HC);
        for (int dr = -HR; dr <= HR; dr++)
          for (int dc = -HC; dc <= HC; dc++)
            if (!(dr == 0 && dc == 0) && r+dr >= 0 && r+dr < H && c+dc >= 0 && c+dc < W)
              if (fo[r+dr][c+dc] != 0 &&
                  (fd[r+dr][c+dc] - fd[r][c] <= TOL) && (fd[r][c] - fd[r+dr][c+dc] <= TOL))
                sup++;
        if (fo[r][c] == 0) why = 1;
        else if (sup < MINS) why = edge_near ? 6 : 2;
        else begin
          why = 5;
          for (int k = LOOK; k >= 1; k--) begin
            if (c-k >= 0 && kept[r][c-k] != 0 && fd[r][c-k] == fd[r][c]) why = 3;
          end
          if (why == 5)
            for (int k = 1; k <= LOOK; k++)
              if (r-k >= 0 && kept[r-k][c] != 0 && fd[r-k][c] == fd[r][c]) why = 4;
        end
        kept[r][c] = (why == 5);
        i = p + r*W + c;
        st_sof[i] = (r == 0 && c == 0);
        st_ok[i]  = (fo[r][c] != 0);
        st_d[i]   = fd[r][c];
        ex_ok[i]  = (why == 5);
        ex_d[i]   = (why == 5) ? fd[r][c] : 0;
        ex_why[i] = why;
      end
  endtask

  task automatic check_sample(input int j);
    vectors++;
    if (out_sof !== st_sof[j] || out_ok !== ex_ok[j] || out_disp !== DW'(ex_d[j])) begin
      errors++;
      $display("FAIL %s sample %0d: got sof=%0b ok=%0b disp=%0d, expected sof=%0b ok=%0b disp=%0d",
               tag(ex_why[j], st_sof[j]), j, out_sof, out_ok, out_disp,
               st_sof[j], ex_ok[j], ex_d[j]);
    end
  endtask

  initial begin
    int p;
    for (int i = 0; i < N; i++) begin
      st_sof[i] = 0; st_ok[i] = 0; st_d[i] = 0;
      ex_ok[i] = 0; ex_d[i] = 0; ex_why[i] = 0;
    end
    p = 5;  place(0, p); p += W*H;
    p += 7; place(1, p); p += W*H;
    place(2, p); p += W*H;             // back to back (R9)
    p += 3; place(3, p); p += W*H;
    place(4, p); p += W*H;
    ns = p + LAT + 5;

    rst_n = 1'b1; in_sof = 1'b0; in_ok = 1'b0; in_disp = '0;
    #1 rst_n = 1'b0;
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      vectors++;
      if (out_ok !== 1'b0 || out_sof !== 1'b0 || out_disp !== '0) begin
        errors++;
        $display("FAIL R1 reset: got ok=%0b sof=%0b disp=%0d, expected 0 0 0",
                 out_ok, out_sof, out_disp);
      end
    end
    rst_n = 1'b1;
    for (int n = 0; n < 4; n++) @(negedge clk);

    for (int e = 0; e < ns; e++) begin
      @(negedge clk);
      if (e - 1 - LAT >= 0) check_sample(e - 1 - LAT);
      in_sof  = st_sof[e];
      in_ok   = st_ok[e];
      in_disp = DW'(st_d[e]);
    end
    @(negedge clk);
    check_sample(ns - 1 - LAT);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule